// File: doc/BRIEF.md
# Dual-Bank Concurrency and Status Controller

This controller sits between the command decoder of a two-bank flash device and its array. The address space is split unevenly into a small bank (one quarter of the words) and a large bank (three quarters). A parameter places the small bank at the low or the high end of the address space. The decoder hands over program, sector-erase, block-erase and chip-erase requests. The controller decides whether each request may start. When it accepts one, it marks the target bank busy, derives the address range the operation covers, and signals a start to an external timer model. That timer later returns a completion pulse.

While an operation is running, reads aimed at the other bank pass array data straight through. Reads aimed at a busy bank return a status word instead. That word carries a data-polling bit and a toggle bit, and an active-low ready/busy output stays low while any work is in progress. A write-protect input guards an 8 KWord region at the outer end of the small bank. Only one operation runs at a time, and a chip erase occupies both banks.

Top module: `dbc_ctrl`

## Requirements
- R1: With the default placement (`SMALL_TOP`=0), addresses whose two top bits are 00 belong to the small bank (bank index 0, bit 0 of `bank_busy`), and all other addresses belong to the large bank (bank index 1, bit 1 of `bank_busy`).
- R2: A request on `req_valid` that is accepted sets the target bank's bit in `bank_busy` at the next clock edge. At that same edge `op_start` goes high for exactly one cycle. The `req_op` encoding is 0 program, 1 sector erase, 2 block erase, 3 chip erase.
- R3: A read of a bank that is not busy returns `arr_data` unchanged with `rd_is_status` low, even while the other bank is busy.
- R4: A read of a busy bank returns a status word with `rd_is_status` high. Bit 7 is the inverse of the latched `req_dq7` for a program and 0 for an erase. Bit 6 is 0 on the first status read after the start and inverts on each later status read of that bank. All other bits are 0.
- R5: A request that arrives while any bank is busy is ignored: `bank_busy`, `op_start` and the scope outputs do not change.
- R6: While `wp_n` is low, any request whose range touches word addresses 0 to 8191 (the default placement) is ignored, and this includes chip erase. While `wp_n` is high, the region may be written.
- R7: On acceptance `scope_first` and `scope_last` give the covered range. For a program both equal the address. A sector erase covers the aligned 2048-word span. A block erase covers the aligned 32768-word span. A chip erase covers the whole space.
- R8: `ry_by_n` is low exactly while any `bank_busy` bit is set. An `op_done` pulse clears every busy bit at the next edge, and a pulse while idle has no effect.
- R9: An accepted chip erase sets both busy bits, and reads to either bank then return status.
- R10: After reset no bank is busy, `ry_by_n` is high and `op_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Operation request strobe from the command decoder |
| req_op | input | 2 | Operation code (0 program, 1 sector, 2 block, 3 chip) |
| req_addr | input | ADDR_W | Latched word address of the request |
| req_dq7 | input | 1 | Bit 7 of the data being programmed |
| op_done | input | 1 | Completion pulse from the timer model |
| wp_n | input | 1 | Write protect, low protects the guarded region |
| rd_en | input | 1 | Read access strobe |
| rd_addr | input | ADDR_W | Read word address |
| arr_data | input | DATA_W | Array data for the read address |
| rd_data | output | DATA_W | Read result: array data or status word |
| rd_is_status | output | 1 | High when `rd_data` is a status word |
| bank_busy | output | 2 | Busy flag per bank (bit 0 small, bit 1 large) |
| ry_by_n | output | 1 | Ready/busy, low while any bank is busy |
| op_start | output | 1 | One-cycle start pulse to the timer model |
| scope_first | output | ADDR_W | First word address of the accepted operation |
| scope_last | output | ADDR_W | Last word address of the accepted operation |

## Verification
A busy flag set on the wrong bank shows up on the very next read of either bank: array data comes back where status was expected, or the reverse, and `bank_busy` disagrees within one cycle of acceptance. A stuck or lost busy bit shows at `ry_by_n` immediately and after the next completion pulse. A wrong protection or conflict decision shows as an `op_start` pulse one cycle after the offending request. A toggle or polling register that is out of step shows up on the second consecutive status read.

// File: rtl/dbc_pkg.sv
// Shared types for the dual-bank concurrency controller.
// Assumes a two-bit operation code driven by the command decoder.
package dbc_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLK   = 2'd2,
        OP_CHIP  = 2'd3
    } dbc_op_e;

    localparam int NBANK = 2;

endpackage

// File: rtl/dbc_bank_map.sv
// Maps the two top address bits to a bank index.
// Bank 0 is the small quarter-size bank, bank 1 the large one.
// Assumes the small bank is exactly one quarter of the address space.
module dbc_bank_map #(
    parameter bit SMALL_TOP = 1'b0
) (
    input  logic [1:0] top_bits,
    output logic       bank
);

    generate
        if (SMALL_TOP) begin : g_top
            // Small bank occupies the highest quarter.
            always_comb bank = (top_bits == 2'b11) ? 1'b0 : 1'b1;
        end else begin : g_bottom
            // Small bank occupies the lowest quarter.
            always_comb bank = (top_bits == 2'b00) ? 1'b0 : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/dbc_scope.sv
// Derives the address range an operation covers from its latched address.
// Assumes sector and block sizes are powers of two and aligned.
module dbc_scope
    import dbc_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int SECT_W = 11,
    parameter int BLK_W  = 15
) (
    input  dbc_op_e           op,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] first,
    output logic [ADDR_W-1:0] last
);

    localparam logic [ADDR_W-1:0] SECT_MASK = {{(ADDR_W-SECT_W){1'b0}}, {SECT_W{1'b1}}};
    localparam logic [ADDR_W-1:0] BLK_MASK  = {{(ADDR_W-BLK_W){1'b0}}, {BLK_W{1'b1}}};

    // Select the span mask for the operation and apply it.
    always_comb begin
        unique case (op)
            OP_PROG: begin first = addr;              last = addr;             end
            OP_SECT: begin first = addr & ~SECT_MASK; last = addr | SECT_MASK; end
            OP_BLK:  begin first = addr & ~BLK_MASK;  last = addr | BLK_MASK;  end
            default: begin first = '0;                last = '1;               end
        endcase
    end

    // R7: every derived range is ordered.
    always_comb begin
        a_r7_scope_ordered: assert (first <= last);
    end

endmodule

// File: rtl/dbc_guard.sv
// Flags a range that overlaps the write-protected region while protect is active.
// Assumes the guarded region sits at the outer end of the small bank.
module dbc_guard #(
    parameter int ADDR_W    = 21,
    parameter int WP_W      = 13,
    parameter bit SMALL_TOP = 1'b0
) (
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] last,
    input  logic              wp_n,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] WP_MASK = {{(ADDR_W-WP_W){1'b0}}, {WP_W{1'b1}}};

    logic overlap;

    generate
        if (SMALL_TOP) begin : g_top
            // Region is the top WP_MASK+1 words; overlap if range reaches it.
            always_comb overlap = (last >= ~WP_MASK);
        end else begin : g_bottom
            // Region is the bottom WP_MASK+1 words; overlap if range starts in it.
            always_comb overlap = (first <= WP_MASK);
        end
    endgenerate

    // Protection only matters while the input is driven low.
    always_comb hit = overlap && !wp_n;

endmodule

// File: rtl/dbc_bank_state.sv
// Per-bank busy flag, polling bit and toggle bit.
// Assumes set and clear come from the top and set only arrives while idle.
module dbc_bank_state #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic              clr,
    input  logic              is_prog,
    input  logic              dq7_in,
    input  logic              stat_rd,
    output logic              busy,
    output logic [DATA_W-1:0] status
);

    logic prog_q;
    logic poll_q;
    logic tog_q;

    // Track busy state and latch status bits at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            prog_q <= 1'b0;
            poll_q <= 1'b0;
            tog_q  <= 1'b0;
        end else if (set) begin
            busy   <= 1'b1;
            prog_q <= is_prog;
            poll_q <= ~dq7_in;
            tog_q  <= 1'b0;
        end else if (clr) begin
            busy   <= 1'b0;
        end else if (stat_rd && busy) begin
            tog_q  <= ~tog_q;
        end
    end

    // Assemble the status word: polling bit 7, toggle bit 6.
    always_comb begin
        status    = '0;
        status[7] = busy && prog_q && poll_q;
        status[6] = busy && tog_q;
    end

    // R4: consecutive status reads see alternating toggle values.
    a_r4_toggle_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stat_rd && !set && !clr) |=> (status[6] != $past(status[6])));

    // R8: a completion clears the bank.
    a_r8_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !busy);

endmodule

// File: rtl/dbc_ctrl.sv
// Dual-bank concurrency and status controller.
// Accepts one program or erase at a time, routes reads to array data or
// per-bank status, applies write protection and drives ready/busy.
// Assumes the timer model pulses op_done once per accepted operation.
module dbc_ctrl
    import dbc_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int SECT_W    = 11,
    parameter int BLK_W     = 15,
    parameter int WP_W      = 13,
    parameter bit SMALL_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_dq7,
    input  logic              op_done,
    input  logic              wp_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_is_status,
    output logic [1:0]        bank_busy,
    output logic              ry_by_n,
    output logic              op_start,
    output logic [ADDR_W-1:0] scope_first,
    output logic [ADDR_W-1:0] scope_last
);

    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    dbc_op_e           op;
    logic              req_bank;
    logic              rd_bank;
    logic [ADDR_W-1:0] nx_first;
    logic [ADDR_W-1:0] nx_last;
    logic              prot_hit;
    logic              any_busy;
    logic              accept;
    logic [1:0]        set_vec;
    logic [1:0]        stat_rd;
    logic [DATA_W-1:0] bank_status [NBANK];

    // Cast the raw operation code to the shared type.
    always_comb op = dbc_op_e'(req_op);

    dbc_bank_map #(.SMALL_TOP(SMALL_TOP)) u_req_map (
        .top_bits (req_addr[ADDR_W-1:ADDR_W-2]),
        .bank     (req_bank)
    );

    dbc_bank_map #(.SMALL_TOP(SMALL_TOP)) u_rd_map (
        .top_bits (rd_addr[ADDR_W-1:ADDR_W-2]),
        .bank     (rd_bank)
    );

    dbc_scope #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_scope (
        .op    (op),
        .addr  (req_addr),
        .first (nx_first),
        .last  (nx_last)
    );

    dbc_guard #(.ADDR_W(ADDR_W), .WP_W(WP_W), .SMALL_TOP(SMALL_TOP)) u_guard (
        .first (nx_first),
        .last  (nx_last),
        .wp_n  (wp_n),
        .hit   (prot_hit)
    );

    // Decide acceptance and which banks an accepted request occupies.
    always_comb begin
        any_busy = |bank_busy;
        accept   = req_valid && !any_busy && !prot_hit;
        if (op == OP_CHIP) set_vec = 2'b11;
        else               set_vec = req_bank ? 2'b10 : 2'b01;
    end

    // Register the start pulse and the operation range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start    <= 1'b0;
            scope_first <= '0;
            scope_last  <= '0;
        end else begin
            op_start <= accept;
            if (accept) begin
                scope_first <= nx_first;
                scope_last  <= nx_last;
            end
        end
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            // Status reads count only against the addressed busy bank.
            always_comb stat_rd[b] = rd_en && (rd_bank == b[0]) && bank_busy[b];

            dbc_bank_state #(.DATA_W(DATA_W)) u_state (
                .clk     (clk),
                .rst_n   (rst_n),
                .set     (accept && set_vec[b]),
                .clr     (op_done),
                .is_prog (op == OP_PROG),
                .dq7_in  (req_dq7),
                .stat_rd (stat_rd[b]),
                .busy    (bank_busy[b]),
                .status  (bank_status[b])
            );
        end
    endgenerate

    // Route a read to status or array data; drive ready/busy.
    always_comb begin
        rd_is_status = rd_en && bank_busy[rd_bank];
        rd_data      = rd_is_status ? bank_status[rd_bank] : arr_data;
        ry_by_n      = ~any_busy;
    end

    // R2: a start pulse always coincides with a busy bank.
    a_r2_start_has_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (bank_busy != 2'b00));

    // R5: a request during a busy period never starts.
    a_r5_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any_busy) |=> !op_start);

    // R6: a protected request never starts.
    a_r6_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_hit) |=> !op_start);

    // R9: a full-range start occupies both banks.
    a_r9_chip_both_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && scope_first == '0 && scope_last == ALL_ONES) |-> (bank_busy == 2'b11));

    // R8: completion empties every bank.
    a_r8_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !accept) |=> (bank_busy == 2'b00));

endmodule

// File: tb/sim_dbc_ctrl.sv
// Scoreboard bench: driver tasks push expected values, a monitor compares.
module sim_dbc_ctrl;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 16;

    typedef struct {
        int          sel;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_op = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_dq7 = 1'b0;
    logic              op_done = 1'b0;
    logic              wp_n = 1'b1;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] arr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_is_status;
    logic [1:0]        bank_busy;
    logic              ry_by_n;
    logic              op_start;
    logic [ADDR_W-1:0] scope_first;
    logic [ADDR_W-1:0] scope_last;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done_flag = 1'b0;

    always #5 clk = ~clk;

    dbc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_dq7(req_dq7), .op_done(op_done), .wp_n(wp_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data),
        .rd_is_status(rd_is_status), .bank_busy(bank_busy), .ry_by_n(ry_by_n),
        .op_start(op_start), .scope_first(scope_first), .scope_last(scope_last)
    );

    function automatic logic [31:0] probe(int sel);
        case (sel)
            0: return 32'(rd_data);
            1: return 32'(rd_is_status);
            2: return 32'(bank_busy);
            3: return 32'(ry_by_n);
            4: return 32'(op_start);
            5: return 32'(scope_first);
            default: return 32'(scope_last);
        endcase
    endfunction

    task automatic expect_val(int sel, logic [31:0] val, string tag);
        exp_t e;
        e.sel = sel; e.val = val; e.tag = tag;
        q.push_back(e);
    endtask

    // Start of a cycle: clear strobes at the falling edge.
    task automatic tick();
        @(negedge clk);
        req_valid = 1'b0; rd_en = 1'b0; op_done = 1'b0;
    endtask

    task automatic request(logic [1:0] op, logic [ADDR_W-1:0] a, logic d7);
        tick();
        req_valid = 1'b1; req_op = op; req_addr = a; req_dq7 = d7;
    endtask

    task automatic read(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] arr);
        tick();
        rd_en = 1'b1; rd_addr = a; arr_data = arr;
        #1;
    endtask

    task automatic after(); tick(); #1; endtask

    task automatic complete(string tag);
        tick(); op_done = 1'b1;
        after();
        expect_val(2, 0, tag); expect_val(3, 1, tag);
    endtask

    // Monitor: compare all queued expectations after the outputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (probe(e.sel) !== e.val) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", e.tag, e.sel, probe(e.sel), e.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        after();
        expect_val(2, 0, "R10"); expect_val(3, 1, "R10"); expect_val(4, 0, "R10");

        // Program in large bank while protect is low (large bank unaffected).
        wp_n = 1'b0;
        request(2'd0, 21'h100123, 1'b0);
        after();
        expect_val(2, 2'b10, "R1"); expect_val(3, 0, "R8"); expect_val(4, 1, "R2");
        expect_val(5, 21'h100123, "R7"); expect_val(6, 21'h100123, "R7");
        after();
        expect_val(4, 0, "R2");
        read(21'h000010, 16'h1234);
        expect_val(0, 16'h1234, "R3"); expect_val(1, 0, "R3");
        read(21'h100123, 16'hFFFF);
        expect_val(0, 16'h0080, "R4"); expect_val(1, 1, "R4");
        read(21'h100123, 16'hFFFF);
        expect_val(0, 16'h00C0, "R4");
        read(21'h1FFFFF, 16'hFFFF);
        expect_val(0, 16'h0080, "R4");
        // Conflicting request while busy.
        request(2'd1, 21'h040000, 1'b0);
        after();
        expect_val(2, 2'b10, "R5"); expect_val(4, 0, "R5");
        expect_val(5, 21'h100123, "R5");
        complete("R8");
        // Done while idle has no effect.
        complete("R8");

        // Protected region requests while protect is low.
        request(2'd1, 21'h001000, 1'b0);
        after();
        expect_val(2, 0, "R6"); expect_val(4, 0, "R6");
        request(2'd0, 21'h001FFF, 1'b0);
        after();
        expect_val(2, 0, "R6"); expect_val(4, 0, "R6");
        request(2'd2, 21'h004000, 1'b0);
        after();
        expect_val(2, 0, "R6");
        request(2'd3, 21'h000000, 1'b0);
        after();
        expect_val(2, 0, "R6"); expect_val(4, 0, "R6");
        request(2'd0, 21'h002000, 1'b1);
        after();
        expect_val(2, 2'b01, "R6"); expect_val(4, 1, "R6");
        read(21'h002000, 16'hAAAA);
        expect_val(0, 16'h0000, "R4");
        complete("R8");

        // Protect released: sector erase in guarded region.
        wp_n = 1'b1;
        request(2'd1, 21'h001234, 1'b0);
        after();
        expect_val(2, 2'b01, "R6"); expect_val(5, 21'h001000, "R7"); expect_val(6, 21'h0017FF, "R7");
        read(21'h000000, 16'h5555);
        expect_val(0, 16'h0000, "R4"); expect_val(1, 1, "R4");
        read(21'h07FFFF, 16'h5555);
        expect_val(0, 16'h0040, "R4");
        read(21'h080000, 16'h5A5A);
        expect_val(0, 16'h5A5A, "R1"); expect_val(1, 0, "R3");
        complete("R8");

        // Block erase in large bank.
        request(2'd2, 21'h123456, 1'b0);
        after();
        expect_val(2, 2'b10, "R7"); expect_val(5, 21'h120000, "R7"); expect_val(6, 21'h127FFF, "R7");
        complete("R8");

        // Chip erase.
        request(2'd3, 21'h0ABCDE, 1'b0);
        after();
        expect_val(2, 2'b11, "R9"); expect_val(5, 21'h000000, "R9"); expect_val(6, 21'h1FFFFF, "R9");
        read(21'h150000, 16'h7777);
        expect_val(0, 16'h0000, "R9"); expect_val(1, 1, "R9");
        read(21'h000100, 16'h7777);
        expect_val(0, 16'h0000, "R9"); expect_val(1, 1, "R9");
        read(21'h150000, 16'h7777);
        expect_val(0, 16'h0040, "R9");
        complete("R9");
        read(21'h150000, 16'h7777);
        expect_val(0, 16'h7777, "R3"); expect_val(1, 0, "R3");

        after();
        after();
        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule